// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host byte-serial access to a network controller's packet memory through a single data port. The host first programs a 16-bit start address, a 16-bit byte count and the two page bounds of the receive ring through a small register-write interface. It then issues data port accesses of 1, 2 or 4 bytes. Each access moves data at the current address, steps the address and consumes the count. When the count is used up, a sticky completion flag is raised.

The packet memory map is sparse. A 32-byte address PROM sits at the bottom of the space and a packet RAM window sits higher up; every other address reads as zero and swallows writes. At reset the PROM takes a fixed image that holds the station address. The address pointer follows the ring: when an access carries it onto the ring's stop boundary, it jumps back to the ring's start.

Top module: `rdma_data_port`

## Requirements
- R1: After reset the address, count and ring page registers are zero, `dma_done` and `dp_rvalid` are low, and the PROM holds 0xFF in all 32 bytes except these: byte k (k = 0..5) holds `mac_addr[8k+7:8k]`, and bytes 14 and 15 hold 0x57.
- R2: A register write with `cfg_we` high loads `cfg_wdata` into the field chosen by `cfg_sel`: 0 = address bits 7:0, 1 = address bits 15:8, 2 = count bits 7:0, 3 = count bits 15:8, 4 = ring start page, 5 = ring stop page. Select 6 has no effect. A register write takes effect after any data port access in the same cycle.
- R3: `dp_size` gives the access width in bytes. Only 1, 2 and 4 are legal. A request with any other value is ignored: no read data, no memory change, no change to address, count or `dma_done`.
- R4: Multi-byte accesses are little-endian: lane i (bits 8i+7:8i) maps to address+i. A read request returns its data on `dp_rdata` with a one-cycle `dp_rvalid` pulse in the cycle after the request. Bytes above the access width read as zero.
- R5: Each accepted access advances the address by the access width, modulo 2^16. If the result equals {ring stop page, 0x00}, the address becomes {ring start page, 0x00} instead.
- R6: On each accepted access, if the count is less than or equal to the width, the count becomes zero and `dma_done` is set. Otherwise the count drops by the width. `dma_done` is sticky.
- R7: A write request while the count is zero is ignored: the memory, address, count and `dma_done` are unchanged. Read requests are accepted whatever the count.
- R8: Only addresses 0..31 (PROM) and RAM_BASE..RAM_BASE+RAM_BYTES-1 (RAM, by default 0x4000..0x43FF) are backed. This is decided per byte: a write to an unbacked byte is dropped and a read of one returns 0x00. PROM bytes are writable.
- R9: A register write with `cfg_sel` = 7 and `cfg_wdata[0]` = 1 clears `dma_done`. With `cfg_wdata[0]` = 0 it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_addr | input | 48 | Station address loaded into the PROM at reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register write target select |
| cfg_wdata | input | 8 | Register write data |
| dp_req | input | 1 | Data port access strobe |
| dp_we | input | 1 | Data port access is a write |
| dp_size | input | 3 | Access width in bytes |
| dp_wdata | input | 32 | Write data, little-endian lanes |
| dp_rdata | output | 32 | Read data |
| dp_rvalid | output | 1 | Read data valid pulse |
| dma_done | output | 1 | Sticky remote transfer complete flag |

## Verification
A corrupted address pointer shows up at the very next read as wrong bytes on `dp_rdata`. A pointer that misses the ring wrap appears after the first access that crosses the stop boundary. A wrong count shows up as `dma_done` rising one access too early or too late, or as a write that lands when it should be dropped. A bad map decode or byte-lane order appears as a nonzero byte read from a hole or as swapped bytes within a word. Because the bench model predicts `dp_rvalid`, `dp_rdata` and `dma_done` for every clock, any of these faults is reported in the cycle it first reaches a port.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    localparam int LANES = 4;

    typedef enum logic [2:0] {
        SEL_ADDR_LO    = 3'd0,
        SEL_ADDR_HI    = 3'd1,
        SEL_CNT_LO     = 3'd2,
        SEL_CNT_HI     = 3'd3,
        SEL_RING_START = 3'd4,
        SEL_RING_STOP  = 3'd5,
        SEL_RSVD       = 3'd6,
        SEL_CLEAR      = 3'd7
    } cfg_sel_e;

    function automatic logic size_legal(input logic [2:0] s);
        return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
    endfunction

endpackage

// File: rtl/rdma_mem.sv
module rdma_mem
    import rdma_pkg::*;
#(
    parameter int AW         = 16,
    parameter int PROM_BYTES = 32,
    parameter int RAM_BASE   = 16384,
    parameter int RAM_BYTES  = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [47:0]                mac_addr,
    input  logic [LANES-1:0][AW-1:0]   lane_addr,
    input  logic [LANES-1:0]           lane_we,
    input  logic [LANES-1:0][7:0]      lane_wdata,
    output logic [LANES-1:0][7:0]      lane_rdata
);

    localparam int PIW = $clog2(PROM_BYTES);
    localparam int RIW = $clog2(RAM_BYTES);

    logic [PROM_BYTES-1:0][7:0] prom_d, prom_q;
    logic [7:0]                 ram [RAM_BYTES];

    logic [LANES-1:0]           prom_hit, ram_hit;
    logic [LANES-1:0][PIW-1:0]  pidx;
    logic [LANES-1:0][RIW-1:0]  ridx;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [31:0] a32;
        assign a32         = 32'(lane_addr[i]);
        assign prom_hit[i] = a32 < 32'(PROM_BYTES);
        assign ram_hit[i]  = (a32 >= 32'(RAM_BASE)) && (a32 < 32'(RAM_BASE + RAM_BYTES));
        assign pidx[i]     = PIW'(a32);
        assign ridx[i]     = RIW'(a32 - 32'(RAM_BASE));
        assign lane_rdata[i] = prom_hit[i] ? prom_q[pidx[i]] :
                               ram_hit[i]  ? ram[ridx[i]]    : 8'h00;
    end

    always_comb begin
        prom_d = prom_q;
        for (int i = 0; i < LANES; i++) begin
            if (lane_we[i] && prom_hit[i]) begin
                prom_d[pidx[i]] = lane_wdata[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < PROM_BYTES; k++) begin
                prom_q[k] <= 8'hFF;
            end
            for (int k = 0; k < 6; k++) begin
                prom_q[k] <= mac_addr[8*k +: 8];
            end
            prom_q[14] <= 8'h57;
            prom_q[15] <= 8'h57;
        end else begin
            prom_q <= prom_d;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (lane_we[i] && ram_hit[i]) begin
                ram[ridx[i]] <= lane_wdata[i];
            end
        end
    end

endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
    import rdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [2:0]                 cfg_sel,
    input  logic [7:0]                 cfg_wdata,
    input  logic                       dp_req,
    input  logic                       dp_we,
    input  logic [2:0]                 dp_size,
    input  logic [8*LANES-1:0]         dp_wdata,
    input  logic [LANES-1:0][7:0]      lane_rdata,
    output logic [LANES-1:0][AW-1:0]   lane_addr,
    output logic [LANES-1:0]           lane_we,
    output logic [LANES-1:0][7:0]      lane_wdata,
    output logic [8*LANES-1:0]         dp_rdata,
    output logic                       dp_rvalid,
    output logic                       dma_done
);

    localparam int PW = AW - 8;

    typedef struct packed {
        logic [AW-1:0]        addr;
        logic [CW-1:0]        cnt;
        logic [PW-1:0]        ring_lo;
        logic [PW-1:0]        ring_hi;
        logic                 done;
        logic                 rvalid;
        logic [8*LANES-1:0]   rdata;
    } st_t;

    st_t s_d, s_q;

    logic          legal, rd, wr, acc;
    logic [AW-1:0] nxt;
    logic [CW-1:0] step_c;

    assign legal  = size_legal(dp_size);
    assign rd     = dp_req && !dp_we && legal;
    assign wr     = dp_req && dp_we && legal && (s_q.cnt != '0);
    assign acc    = rd || wr;
    assign step_c = CW'(dp_size);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_addr[i]  = s_q.addr + AW'(i);
        assign lane_wdata[i] = dp_wdata[8*i +: 8];
        assign lane_we[i]    = wr && (32'(i) < 32'(dp_size));
    end

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        nxt        = s_q.addr + AW'(dp_size);

        if (rd) begin
            s_d.rvalid = 1'b1;
            s_d.rdata  = '0;
            for (int i = 0; i < LANES; i++) begin
                if (32'(i) < 32'(dp_size)) begin
                    s_d.rdata[8*i +: 8] = lane_rdata[i];
                end
            end
        end

        if (acc) begin
            if (nxt == {s_q.ring_hi, 8'h00}) begin
                s_d.addr = {s_q.ring_lo, 8'h00};
            end else begin
                s_d.addr = nxt;
            end
            if (s_q.cnt <= step_c) begin
                s_d.cnt  = '0;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - step_c;
            end
        end

        if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_ADDR_LO:    s_d.addr[7:0]    = cfg_wdata;
                SEL_ADDR_HI:    s_d.addr[15:8]   = cfg_wdata;
                SEL_CNT_LO:     s_d.cnt[7:0]     = cfg_wdata;
                SEL_CNT_HI:     s_d.cnt[15:8]    = cfg_wdata;
                SEL_RING_START: s_d.ring_lo      = cfg_wdata;
                SEL_RING_STOP:  s_d.ring_hi      = cfg_wdata;
                SEL_CLEAR:      if (cfg_wdata[0]) s_d.done = 1'b0;
                default:        ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dp_rdata  = s_q.rdata;
    assign dp_rvalid = s_q.rvalid;
    assign dma_done  = s_q.done;

    // R6
    cnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we) |=> (s_q.cnt <= $past(s_q.cnt)));

    // R7
    zero_cnt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_req && dp_we && (s_q.cnt == '0)) |-> (lane_we == '0));

    // R4
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rvalid |-> $past(dp_req && !dp_we));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !dp_req) |=> $stable(s_q.addr));

    // R9
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_done) |-> $past(dp_req));

endmodule

// File: rtl/rdma_data_port.sv
module rdma_data_port
    import rdma_pkg::*;
#(
    parameter int AW         = 16,
    parameter int CW         = 16,
    parameter int PROM_BYTES = 32,
    parameter int RAM_BASE   = 16384,
    parameter int RAM_BYTES  = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [47:0] mac_addr,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [7:0]  cfg_wdata,
    input  logic        dp_req,
    input  logic        dp_we,
    input  logic [2:0]  dp_size,
    input  logic [31:0] dp_wdata,
    output logic [31:0] dp_rdata,
    output logic        dp_rvalid,
    output logic        dma_done
);

    logic [LANES-1:0][AW-1:0] lane_addr;
    logic [LANES-1:0]         lane_we;
    logic [LANES-1:0][7:0]    lane_wdata;
    logic [LANES-1:0][7:0]    lane_rdata;

    rdma_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .dp_req     (dp_req),
        .dp_we      (dp_we),
        .dp_size    (dp_size),
        .dp_wdata   (dp_wdata),
        .lane_rdata (lane_rdata),
        .lane_addr  (lane_addr),
        .lane_we    (lane_we),
        .lane_wdata (lane_wdata),
        .dp_rdata   (dp_rdata),
        .dp_rvalid  (dp_rvalid),
        .dma_done   (dma_done)
    );

    rdma_mem #(
        .AW         (AW),
        .PROM_BYTES (PROM_BYTES),
        .RAM_BASE   (RAM_BASE),
        .RAM_BYTES  (RAM_BYTES)
    ) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .mac_addr   (mac_addr),
        .lane_addr  (lane_addr),
        .lane_we    (lane_we),
        .lane_wdata (lane_wdata),
        .lane_rdata (lane_rdata)
    );

endmodule

// File: tb/tb_rdma_data_port.sv
`timescale 1ns/1ps
module tb_rdma_data_port;

    localparam int RAM_BASE  = 16384;
    localparam int RAM_BYTES = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] mac_addr = 48'h665544332211;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        dp_req = 1'b0;
    logic        dp_we = 1'b0;
    logic [2:0]  dp_size = '0;
    logic [31:0] dp_wdata = '0;
    logic [31:0] dp_rdata;
    logic        dp_rvalid;
    logic        dma_done;

    int checks = 0;
    int failures = 0;

    int m_addr, m_cnt, m_lo, m_hi;
    bit m_done;
    logic [7:0] mm [int];

    always #10 clk = ~clk;

    rdma_data_port dut (
        .clk(clk), .rst_n(rst_n), .mac_addr(mac_addr),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .dp_req(dp_req), .dp_we(dp_we), .dp_size(dp_size), .dp_wdata(dp_wdata),
        .dp_rdata(dp_rdata), .dp_rvalid(dp_rvalid), .dma_done(dma_done)
    );

    function automatic bit backed(int a);
        return (a < 32) || (a >= RAM_BASE && a < RAM_BASE + RAM_BYTES);
    endfunction

    function automatic logic [7:0] rbyte(int a);
        if (!backed(a)) return 8'h00;
        if (mm.exists(a)) return mm[a];
        return 8'h00;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_addr = 0; m_cnt = 0; m_lo = 0; m_hi = 0; m_done = 0;
        mm.delete();
        for (int k = 0; k < 32; k++) mm[k] = 8'hFF;
        for (int k = 0; k < 6; k++) mm[k] = mac_addr[8*k +: 8];
        mm[14] = 8'h57;
        mm[15] = 8'h57;
    endtask

    task automatic step(bit req, bit we, logic [2:0] sz, logic [31:0] wd,
                        bit cw, logic [2:0] cs, logic [7:0] cd, string tag);
        bit          erv;
        logic [31:0] erd;
        bit          legal;
        bit          acc;
        int          na;
        dp_req = req; dp_we = we; dp_size = sz; dp_wdata = wd;
        cfg_we = cw; cfg_sel = cs; cfg_wdata = cd;
        erv = 0; erd = '0; acc = 0;
        legal = (sz == 1) || (sz == 2) || (sz == 4);
        if (req && legal) begin
            if (!we) begin
                erv = 1;
                acc = 1;
                for (int i = 0; i < int'(sz); i++) erd[8*i +: 8] = rbyte((m_addr + i) & 16'hFFFF);
            end else if (m_cnt != 0) begin
                acc = 1;
                for (int i = 0; i < int'(sz); i++) begin
                    na = (m_addr + i) & 16'hFFFF;
                    if (backed(na)) mm[na] = wd[8*i +: 8];
                end
            end
        end
        if (acc) begin
            na = (m_addr + int'(sz)) & 16'hFFFF;
            if (na == m_hi * 256) na = m_lo * 256;
            m_addr = na;
            if (m_cnt <= int'(sz)) begin
                m_cnt = 0;
                m_done = 1;
            end else begin
                m_cnt = m_cnt - int'(sz);
            end
        end
        if (cw) begin
            case (cs)
                3'd0: m_addr = (m_addr & 16'hFF00) | int'(cd);
                3'd1: m_addr = (m_addr & 16'h00FF) | (int'(cd) << 8);
                3'd2: m_cnt  = (m_cnt & 16'hFF00) | int'(cd);
                3'd3: m_cnt  = (m_cnt & 16'h00FF) | (int'(cd) << 8);
                3'd4: m_lo   = int'(cd);
                3'd5: m_hi   = int'(cd);
                3'd7: if (cd[0]) m_done = 0;
                default: ;
            endcase
        end
        @(negedge clk);
        check({tag, " rvalid"}, {31'b0, dp_rvalid}, {31'b0, erv});
        if (erv) check({tag, " rdata"}, dp_rdata, erd);
        check({tag, " done"}, {31'b0, dma_done}, {31'b0, m_done});
        dp_req = 0; cfg_we = 0;
    endtask

    task automatic cfg(logic [2:0] s, logic [7:0] d, string tag);
        step(0, 0, 3'd0, 32'h0, 1, s, d, tag);
    endtask

    task automatic set_addr(int a, string tag);
        cfg(3'd0, 8'(a), tag);
        cfg(3'd1, 8'(a >> 8), tag);
    endtask

    task automatic set_cnt(int c, string tag);
        cfg(3'd2, 8'(c), tag);
        cfg(3'd3, 8'(c >> 8), tag);
    endtask

    task automatic rd(logic [2:0] sz, string tag);
        step(1, 0, sz, 32'h0, 0, 3'd0, 8'h0, tag);
    endtask

    task automatic wr(logic [2:0] sz, logic [31:0] d, string tag);
        step(1, 1, sz, d, 0, 3'd0, 8'h0, tag);
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check("R1 rvalid after reset", {31'b0, dp_rvalid}, 32'h0);
        check("R1 done after reset", {31'b0, dma_done}, 32'h0);

        // R1 / R4 PROM image, mixed widths, little-endian
        set_cnt(32, "R2");
        rd(3'd4, "R1");
        rd(3'd2, "R1");
        rd(3'd2, "R1");
        rd(3'd4, "R1");
        rd(3'd2, "R1");
        rd(3'd2, "R1");
        rd(3'd4, "R4");
        rd(3'd4, "R4");
        rd(3'd1, "R4");
        rd(3'd2, "R4");
        rd(3'd1, "R6");
        rd(3'd4, "R6");

        // R9 clear
        cfg(3'd7, 8'h00, "R9");
        cfg(3'd7, 8'h01, "R9");
        cfg(3'd6, 8'hFF, "R2");

        // R3 illegal widths ignored, address unchanged
        set_addr(0, "R2");
        set_cnt(8, "R2");
        rd(3'd3, "R3");
        rd(3'd0, "R3");
        wr(3'd7, 32'hCAFEF00D, "R3");
        rd(3'd1, "R3");
        rd(3'd4, "R3");

        // R5 ring wrap
        cfg(3'd4, 8'h40, "R5");
        cfg(3'd5, 8'h41, "R5");
        cfg(3'd7, 8'h01, "R9");
        set_addr(16'h40F8, "R5");
        set_cnt(16, "R5");
        wr(3'd4, 32'h04030201, "R5");
        wr(3'd4, 32'h08070605, "R5");
        wr(3'd4, 32'h0C0B0A09, "R5");
        wr(3'd4, 32'h100F0E0D, "R6");
        set_addr(16'h40F8, "R5");
        set_cnt(16, "R5");
        rd(3'd4, "R5");
        rd(3'd4, "R5");
        rd(3'd4, "R5");
        rd(3'd4, "R5");

        // R7 write with zero count ignored
        cfg(3'd7, 8'h01, "R9");
        set_addr(16'h4010, "R7");
        set_cnt(4, "R7");
        wr(3'd4, 32'h11223344, "R7");
        set_addr(16'h4010, "R7");
        wr(3'd4, 32'hDEADBEEF, "R7");
        wr(3'd1, 32'h000000AA, "R7");
        set_cnt(4, "R7");
        rd(3'd4, "R7");

        // R8 sparse map
        cfg(3'd7, 8'h01, "R9");
        set_addr(16'h0020, "R8");
        set_cnt(64, "R8");
        wr(3'd4, 32'hAABBCCDD, "R8");
        set_addr(16'h0020, "R8");
        rd(3'd4, "R8");
        set_addr(16'h001E, "R8");
        rd(3'd4, "R8");
        set_addr(16'h3FFF, "R8");
        rd(3'd2, "R8");
        set_addr(16'h001C, "R8");
        wr(3'd4, 32'h5A6B7C8D, "R8");
        set_addr(16'h001C, "R8");
        rd(3'd4, "R8");
        set_addr(16'h43FE, "R8");
        wr(3'd4, 32'h99887766, "R8");
        set_addr(16'h43FE, "R8");
        rd(3'd4, "R8");

        // R6 partial counts
        cfg(3'd7, 8'h01, "R9");
        set_addr(16'h4000, "R6");
        set_cnt(3, "R6");
        rd(3'd4, "R6");
        cfg(3'd7, 8'h01, "R9");
        set_addr(16'h4000, "R6");
        set_cnt(5, "R6");
        wr(3'd2, 32'h0000BEEF, "R6");
        wr(3'd2, 32'h0000CAFE, "R6");
        wr(3'd2, 32'h00001234, "R6");
        wr(3'd2, 32'h00005678, "R7");
        set_addr(16'h4000, "R6");
        rd(3'd4, "R6");
        rd(3'd2, "R6");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule